// File: doc/BRIEF.md
# Mode-Switchable Floating-Point Register Bank

This block holds the floating-point register state of a processor core: 32 entries of 64 bits. It has a 32-bit access path and a 64-bit access path. Each path has one combinational read port and one write port that is clocked. The register index on each path is remapped according to a layout input, `wideMode`.

With `wideMode` high, every index names its own 64-bit entry. A 32-bit access touches the low half of that entry.

With `wideMode` low, the bank uses the paired legacy layout:
- A 64-bit access always lands on the even entry; the index LSB is ignored.
- A 32-bit access to an even number uses the low half of that entry.
- A 32-bit access to an odd number uses the high half of the even entry just below it.

So one physical entry carries two architectural single registers. A 32-bit write changes only its own half and keeps the other half.

A build parameter restricts the bank to even single registers. In that build, an odd 32-bit index on either path raises an error flag, and the access does not happen. If both write ports hit the same physical entry in one cycle, the 64-bit write is kept, the 32-bit write is discarded and a collision flag is raised.

Top module: `fpr_bank`

## Requirements
- R1: After reset every one of the 32 entries reads as all zeros on the 64-bit read port.
- R2: With `wideMode`=1, a 32-bit read or write at index n uses bits [31:0] of entry n.
- R3: With `wideMode`=0, a 32-bit access at an even index n uses bits [31:0] of entry n. At an odd index n it uses bits [63:32] of entry n-1, and entry n is left untouched.
- R4: A 32-bit write into one half of an entry leaves the other 32 bits of that entry unchanged.
- R5: A 64-bit read or write uses entry n with `wideMode`=1, and entry n with bit 0 cleared with `wideMode`=0.
- R6: When SINGLE_ONLY=1, an odd 32-bit index has these effects:
  - On the read port, `sRdIllegal`=1 and `sRdData` reads zero.
  - On a requested write, `sWrIllegal`=1 and no entry changes.
  - Even indices behave as normal.
- R7: When both writes are enabled and legal and map to the same entry, `wrCollide`=1 in that cycle, the entry takes the 64-bit data and the 32-bit data is lost. Writes to different entries both land and `wrCollide`=0.
- R8: Reads are combinational from the current contents. A write becomes visible only after the rising clock edge, and in the cycle of the write a read of that entry returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wideMode | input | 1 | 1: 32 independent 64-bit entries; 0: paired layout |
| sRdIdx | input | 5 | 32-bit read register number |
| sRdData | output | 32 | 32-bit read data |
| sRdIllegal | output | 1 | Odd 32-bit read index in single-only build |
| sWrEn | input | 1 | 32-bit write request |
| sWrIdx | input | 5 | 32-bit write register number |
| sWrData | input | 32 | 32-bit write data |
| sWrIllegal | output | 1 | Odd 32-bit write index in single-only build |
| dRdIdx | input | 5 | 64-bit read register number |
| dRdData | output | 64 | 64-bit read data |
| dWrEn | input | 1 | 64-bit write request |
| dWrIdx | input | 5 | 64-bit write register number |
| dWrData | input | 64 | 64-bit write data |
| wrCollide | output | 1 | Both writes target one entry; the 32-bit write was dropped |

## Verification
The two write ports can fire in the same cycle on one physical entry. In paired mode this happens even when the register numbers differ: an odd single index and its even double partner land on the same entry. The bench provokes the paired case with a single write to index 9 and a double write to index 8. It provokes the wide case with the same index on both ports. A control case writes different entries in the same cycle.

In each case the bench checks `wrCollide` before the clock edge. After the edge it reads both halves of the target entry and confirms that only the 64-bit data landed.

// File: rtl/fpr_bank_pkg.sv
package fpr_bank_pkg;
  parameter int IDX_W  = 5;
  parameter int HALF_W = 32;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             sWrGo;
    logic             sWrHigh;
    logic [IDX_W-1:0] sWrEntry;
    logic             dWrGo;
    logic [IDX_W-1:0] dWrEntry;
    logic             sRdHigh;
    logic             sRdKill;
    logic [IDX_W-1:0] sRdEntry;
    logic [IDX_W-1:0] dRdEntry;
  } bankStrobe_t;

  // Physical entry selected by a register number under the current layout.
  function automatic logic [IDX_W-1:0] mapEntry(input logic wide,
                                                input logic [IDX_W-1:0] idx);
    return wide ? idx : {idx[IDX_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/fpr_bank_ctrl.sv
module fpr_bank_ctrl
  import fpr_bank_pkg::*;
#(
  parameter bit SINGLE_ONLY = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wideMode,
  input  logic [IDX_W-1:0] sRdIdx,
  input  logic             sWrEn,
  input  logic [IDX_W-1:0] sWrIdx,
  input  logic [IDX_W-1:0] dRdIdx,
  input  logic             dWrEn,
  input  logic [IDX_W-1:0] dWrIdx,
  output bankStrobe_t      strobe,
  output logic             sRdIllegal,
  output logic             sWrIllegal,
  output logic             wrCollide
);
  logic sRdBad, sWrBad;
  logic [IDX_W-1:0] sWrEntry, dWrEntry;

  // Single-only build rejects odd 32-bit register numbers.
  generate
    if (SINGLE_ONLY) begin : gSingleOnly
      assign sRdBad = sRdIdx[0];
      assign sWrBad = sWrEn & sWrIdx[0];
    end else begin : gFullSet
      assign sRdBad = 1'b0;
      assign sWrBad = 1'b0;
    end
  endgenerate

  assign sWrEntry   = mapEntry(wideMode, sWrIdx);
  assign dWrEntry   = mapEntry(wideMode, dWrIdx);
  assign sRdIllegal = sRdBad;
  assign sWrIllegal = sWrBad;
  assign wrCollide  = sWrEn & ~sWrBad & dWrEn & (sWrEntry == dWrEntry);

  always_comb begin
    strobe          = '0;
    strobe.sWrGo    = sWrEn & ~sWrBad & ~wrCollide;
    strobe.sWrHigh  = ~wideMode & sWrIdx[0];
    strobe.sWrEntry = sWrEntry;
    strobe.dWrGo    = dWrEn;
    strobe.dWrEntry = dWrEntry;
    strobe.sRdHigh  = ~wideMode & sRdIdx[0];
    strobe.sRdKill  = sRdBad;
    strobe.sRdEntry = mapEntry(wideMode, sRdIdx);
    strobe.dRdEntry = mapEntry(wideMode, dRdIdx);
  end

  // R6
  illegal_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    sWrIllegal |-> !strobe.sWrGo);

  // R7
  collide_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCollide |-> (strobe.dWrGo && !strobe.sWrGo));
endmodule

// File: rtl/fpr_bank_dp.sv
module fpr_bank_dp
  import fpr_bank_pkg::*;
#(
  parameter int ENTRIES = 1 << IDX_W,
  parameter int FULL_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [HALF_W-1:0] sWrData,
  input  logic [FULL_W-1:0] dWrData,
  output logic [HALF_W-1:0] sRdData,
  output logic [FULL_W-1:0] dRdData
);
  logic [FULL_W-1:0] bank [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) bank[e] <= '0;
    end else begin
      if (strobe.sWrGo) begin
        if (strobe.sWrHigh) bank[strobe.sWrEntry][FULL_W-1:HALF_W] <= sWrData;
        else                bank[strobe.sWrEntry][HALF_W-1:0]      <= sWrData;
      end
      if (strobe.dWrGo) bank[strobe.dWrEntry] <= dWrData;
    end
  end

  always_comb begin
    if (strobe.sRdKill)      sRdData = '0;
    else if (strobe.sRdHigh) sRdData = bank[strobe.sRdEntry][FULL_W-1:HALF_W];
    else                     sRdData = bank[strobe.sRdEntry][HALF_W-1:0];
  end
  assign dRdData = bank[strobe.dRdEntry];

  // R8
  wide_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dWrGo |=> bank[$past(strobe.dWrEntry)] == $past(dWrData));

  // R4
  low_keeps_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sWrGo && !strobe.sWrHigh) |=>
      bank[$past(strobe.sWrEntry)][FULL_W-1:HALF_W] ==
      $past(bank[strobe.sWrEntry][FULL_W-1:HALF_W]));

  // R4
  high_keeps_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sWrGo && strobe.sWrHigh) |=>
      bank[$past(strobe.sWrEntry)][HALF_W-1:0] ==
      $past(bank[strobe.sWrEntry][HALF_W-1:0]));
endmodule

// File: rtl/fpr_bank.sv
module fpr_bank
  import fpr_bank_pkg::*;
#(
  parameter bit SINGLE_ONLY = 1'b0,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wideMode,
  input  logic [IDX_W-1:0]  sRdIdx,
  output logic [HALF_W-1:0] sRdData,
  output logic              sRdIllegal,
  input  logic              sWrEn,
  input  logic [IDX_W-1:0]  sWrIdx,
  input  logic [HALF_W-1:0] sWrData,
  output logic              sWrIllegal,
  input  logic [IDX_W-1:0]  dRdIdx,
  output logic [FULL_W-1:0] dRdData,
  input  logic              dWrEn,
  input  logic [IDX_W-1:0]  dWrIdx,
  input  logic [FULL_W-1:0] dWrData,
  output logic              wrCollide
);
  bankStrobe_t strobe;

  fpr_bank_ctrl #(.SINGLE_ONLY(SINGLE_ONLY)) ctrl_i (
    .clk(clk), .rstN(rstN), .wideMode(wideMode),
    .sRdIdx(sRdIdx), .sWrEn(sWrEn), .sWrIdx(sWrIdx),
    .dRdIdx(dRdIdx), .dWrEn(dWrEn), .dWrIdx(dWrIdx),
    .strobe(strobe), .sRdIllegal(sRdIllegal), .sWrIllegal(sWrIllegal),
    .wrCollide(wrCollide)
  );

  fpr_bank_dp #(.FULL_W(FULL_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sWrData(sWrData), .dWrData(dWrData),
    .sRdData(sRdData), .dRdData(dRdData)
  );
endmodule

// File: tb/fpr_bank_tb_top.sv
module fpr_bank_tb_top;
  typedef struct packed {
    logic [3:0]  req;
    logic        mode;
    logic        sEn;
    logic [4:0]  sIdx;
    logic [31:0] sData;
    logic        dEn;
    logic [4:0]  dIdx;
    logic [63:0] dData;
    logic [4:0]  sRd;
    logic [4:0]  dRd;
    logic [31:0] expS;
    logic [63:0] expD;
    logic        expCol;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // R5 wide mode, 64-bit at index 3
    '{4'd5, 1'b1, 1'b0, 5'd0,  32'h0,         1'b1, 5'd3,  64'h1111_2222_3333_4444, 5'd3,  5'd3,  32'h3333_4444, 64'h1111_2222_3333_4444, 1'b0},
    // R2 wide mode single at 5 -> low half of entry 5
    '{4'd2, 1'b1, 1'b1, 5'd5,  32'hAAAA_0005, 1'b0, 5'd0,  64'h0,                  5'd5,  5'd5,  32'hAAAA_0005, 64'h0000_0000_AAAA_0005, 1'b0},
    // R3 paired single at 5 -> high half of entry 4
    '{4'd3, 1'b0, 1'b1, 5'd5,  32'hBBBB_0055, 1'b0, 5'd0,  64'h0,                  5'd5,  5'd4,  32'hBBBB_0055, 64'hBBBB_0055_0000_0000, 1'b0},
    // R4 paired single at 4 keeps high half; 64-bit read at 5 maps to entry 4
    '{4'd4, 1'b0, 1'b1, 5'd4,  32'hCCCC_0044, 1'b0, 5'd0,  64'h0,                  5'd4,  5'd5,  32'hCCCC_0044, 64'hBBBB_0055_CCCC_0044, 1'b0},
    // R3 entry 5 untouched by paired access
    '{4'd3, 1'b1, 1'b0, 5'd0,  32'h0,         1'b0, 5'd0,  64'h0,                  5'd5,  5'd5,  32'hAAAA_0005, 64'h0000_0000_AAAA_0005, 1'b0},
    // R5 paired 64-bit write at 7 -> entry 6
    '{4'd5, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd7,  64'h6666_7777_8888_9999, 5'd7,  5'd6,  32'h6666_7777, 64'h6666_7777_8888_9999, 1'b0},
    // R5 entry 7 still zero
    '{4'd5, 1'b1, 1'b0, 5'd0,  32'h0,         1'b0, 5'd0,  64'h0,                  5'd6,  5'd7,  32'h8888_9999, 64'h0,                   1'b0},
    // R7 paired collision: single 9 and double 8 share entry 8
    '{4'd7, 1'b0, 1'b1, 5'd9,  32'hDEAD_0009, 1'b1, 5'd8,  64'h0123_4567_89AB_CDEF, 5'd9,  5'd8,  32'h0123_4567, 64'h0123_4567_89AB_CDEF, 1'b1},
    // R7 different entries both land
    '{4'd7, 1'b1, 1'b1, 5'd10, 32'h0000_000A, 1'b1, 5'd11, 64'hFFFF_FFFF_FFFF_FFFF, 5'd10, 5'd11, 32'h0000_000A, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    // R7 wide collision on index 12
    '{4'd7, 1'b1, 1'b1, 5'd12, 32'h1212_1212, 1'b1, 5'd12, 64'h5555_5555_5555_5555, 5'd12, 5'd12, 32'h5555_5555, 64'h5555_5555_5555_5555, 1'b1},
    // R4 paired single 13 -> high of entry 12, low kept
    '{4'd4, 1'b0, 1'b1, 5'd13, 32'hABCD_ABCD, 1'b0, 5'd0,  64'h0,                  5'd12, 5'd13, 32'h5555_5555, 64'hABCD_ABCD_5555_5555, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  always #4 clk = ~clk;

  logic wideMode = 1'b1;
  logic [4:0] sRdIdx = '0, sWrIdx = '0, dRdIdx = '0, dWrIdx = '0;
  logic sWrEn = 1'b0, dWrEn = 1'b0;
  logic [31:0] sWrData = '0;
  logic [63:0] dWrData = '0;
  logic [31:0] sRdData;
  logic [63:0] dRdData;
  logic sRdIllegal, sWrIllegal, wrCollide;

  logic [31:0] soSRdData;
  logic [63:0] soDRdData;
  logic soSRdIllegal, soSWrIllegal, soCollide;

  fpr_bank dut_i (
    .clk(clk), .rstN(rstN), .wideMode(wideMode),
    .sRdIdx(sRdIdx), .sRdData(sRdData), .sRdIllegal(sRdIllegal),
    .sWrEn(sWrEn), .sWrIdx(sWrIdx), .sWrData(sWrData), .sWrIllegal(sWrIllegal),
    .dRdIdx(dRdIdx), .dRdData(dRdData),
    .dWrEn(dWrEn), .dWrIdx(dWrIdx), .dWrData(dWrData), .wrCollide(wrCollide)
  );

  fpr_bank #(.SINGLE_ONLY(1'b1)) dutSo_i (
    .clk(clk), .rstN(rstN), .wideMode(wideMode),
    .sRdIdx(sRdIdx), .sRdData(soSRdData), .sRdIllegal(soSRdIllegal),
    .sWrEn(sWrEn), .sWrIdx(sWrIdx), .sWrData(sWrData), .sWrIllegal(soSWrIllegal),
    .dRdIdx(dRdIdx), .dRdData(soDRdData),
    .dWrEn(1'b0), .dWrIdx(dWrIdx), .dWrData(dWrData), .wrCollide(soCollide)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset contents
    wideMode = 1'b1;
    for (int e = 0; e < 32; e++) begin
      dRdIdx = e[4:0];
      #1 check("R1 reset entry", dRdData, 64'h0);
    end

    // Vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wideMode = VECS[v].mode;
      sWrEn = VECS[v].sEn;  sWrIdx = VECS[v].sIdx;  sWrData = VECS[v].sData;
      dWrEn = VECS[v].dEn;  dWrIdx = VECS[v].dIdx;  dWrData = VECS[v].dData;
      sRdIdx = VECS[v].sRd; dRdIdx = VECS[v].dRd;
      #1 check($sformatf("R%0d vec%0d collide", VECS[v].req, v), {63'h0, wrCollide}, {63'h0, VECS[v].expCol});
      @(negedge clk);
      sWrEn = 1'b0; dWrEn = 1'b0;
      #1;
      check($sformatf("R%0d vec%0d sRd", VECS[v].req, v), {32'h0, sRdData}, {32'h0, VECS[v].expS});
      check($sformatf("R%0d vec%0d dRd", VECS[v].req, v), dRdData, VECS[v].expD);
    end

    // R8 old value visible before edge, new value after
    @(negedge clk);
    wideMode = 1'b1;
    dWrEn = 1'b1; dWrIdx = 5'd2; dWrData = 64'hFACE_0000_0000_BEEF; dRdIdx = 5'd2;
    #1 check("R8 before edge", dRdData, 64'h0);
    @(negedge clk);
    dWrEn = 1'b0;
    #1 check("R8 after edge", dRdData, 64'hFACE_0000_0000_BEEF);

    // R6 single-only build: odd index rejected
    @(negedge clk);
    sWrEn = 1'b1; sWrIdx = 5'd3; sWrData = 32'h1234_5678; sRdIdx = 5'd3; dRdIdx = 5'd3;
    #1;
    check("R6 write flag odd", {63'h0, soSWrIllegal}, 64'h1);
    check("R6 read flag odd", {63'h0, soSRdIllegal}, 64'h1);
    check("R6 read data odd", {32'h0, soSRdData}, 64'h0);
    @(negedge clk);
    sWrEn = 1'b0;
    #1 check("R6 odd write dropped", soDRdData, 64'h0);
    // R6 even index still works
    @(negedge clk);
    sWrEn = 1'b1; sWrIdx = 5'd2; sWrData = 32'h0BAD_F00D; sRdIdx = 5'd2;
    #1 check("R6 write flag even", {63'h0, soSWrIllegal}, 64'h0);
    @(negedge clk);
    sWrEn = 1'b0;
    #1;
    check("R6 read flag even", {63'h0, soSRdIllegal}, 64'h0);
    check("R6 even data", {32'h0, soSRdData}, {32'h0, 32'h0BAD_F00D});
    // R6 full build unaffected by odd index
    check("R6 full build flag", {63'h0, sRdIllegal}, 64'h0);

    finishRun();
  end
endmodule